// File: doc/BRIEF.md
# Mixed-Precision Integer Matrix Multiply-Accumulate Unit

This block performs one small matrix multiply-accumulate per accepted request, in one of two signed integer modes. In the byte mode, a 4×8 matrix of 8-bit values is multiplied by the transpose of a second 4×8 matrix of 8-bit values, and the 4×4 product is added into sixteen 32-bit accumulators. In the halfword mode, two 4×4 matrices of 16-bit values are multiplied (again with the right operand transposed) and the product is added into sixteen 64-bit accumulators.

Each operand matrix arrives as one 256-bit register image whose four 64-bit quarters are the four rows. The right operand is stored row by row like the left one, so output element (i,j) is the dot product of left row i with right row j. The accumulator arrives and leaves as a 1024-bit image of four consecutive 256-bit registers. The byte mode uses only the lower two registers. A request is accepted with a valid/ready handshake, and the result is held in an output register until the consumer takes it. One operation can complete on every clock.

Top module: `imma_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Byte mode (`in_mode`=0). Left element (i,c) is `in_lhs[64i+8c+7:64i+8c]`, and right element (j,c) is `in_rhs[64j+8c+7:64j+8c]`, for c=0..7. Accumulator element (i,j) is `in_acc[32k+31:32k]` with k=4i+j. The result at the same position is that accumulator plus the sum over c of left(i,c)·right(j,c).
- R3: In byte mode, `out_acc[1023:512]` is zero and `in_acc[1023:512]` has no effect on the result.
- R4: Halfword mode (`in_mode`=1). Left element (i,c) is `in_lhs[64i+16c+15:64i+16c]`, and right element (j,c) is `in_rhs[64j+16c+15:64j+16c]`, for c=0..3. Accumulator element (i,j) is `in_acc[64k+63:64k]` with k=4i+j. The result is that accumulator plus the four-term dot product of left row i with right row j.
- R5: All elements are signed two's complement, and each accumulator element wraps modulo 2^32 (byte mode) or 2^64 (halfword mode).
- R6: A request accepted at a clock edge (`in_valid` and `in_ready` both 1) appears with `out_valid`=1 right after that edge. If a result is taken with no new request accepted, `out_valid` falls.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_acc` and `out_mode` hold their values.
- R8: `in_ready` is 0 exactly when a result is waiting that is not being taken (`out_valid`=1, `out_ready`=0). With `out_ready` held at 1, a new request is accepted on every clock.
- R9: `out_mode` reports the `in_mode` of the request whose result is on `out_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_mode | input | 1 | 0 = 8-bit elements into 32-bit sums, 1 = 16-bit elements into 64-bit sums |
| in_lhs | input | 256 | Left operand, four 64-bit rows |
| in_rhs | input | 256 | Right operand, four 64-bit rows, used transposed |
| in_acc | input | 1024 | Accumulator image, four 256-bit registers |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_mode | output | 1 | Mode of the result |
| out_acc | output | 1024 | Updated accumulator image |

## Verification
The assertions check the handshake on every cycle: the next-cycle valid after an accepted request, valid falling after a drain, values holding during a stall, the ready blocking during a stall, and the upper half being clear in byte mode. The arithmetic itself can only be shown by the bench scenarios, which compare every result against a reference model. These scenarios include the transposed indexing, sign handling with extreme operands, wraparound at both accumulator widths, ignoring the upper accumulator registers in byte mode, and accepting a new request while an old result is being taken.

// File: rtl/imma_pkg.sv
`timescale 1ns/1ps
package imma_pkg;
  // Operation mode carried with every request
  typedef enum logic {
    MODE_I8  = 1'b0,
    MODE_I16 = 1'b1
  } imma_mode_e;

  localparam int DEF_REG_W   = 256;
  localparam int DEF_ROWS    = 4;
  localparam int DEF_ACC8_W  = 32;
  localparam int DEF_ACC16_W = 64;
endpackage

// File: rtl/imma_dot.sv
`timescale 1ns/1ps
// Signed dot product of two rows of N elements, each EW bits wide, added into
// an AW-bit accumulator. The sum wraps modulo 2^AW.
module imma_dot #(
  parameter int EW = 8,
  parameter int N  = 8,
  parameter int AW = 32
) (
  input  logic [EW*N-1:0] a_row,
  input  logic [EW*N-1:0] b_row,
  input  logic [AW-1:0]   acc_in,
  output logic [AW-1:0]   acc_out
);
  localparam int PW = 2 * EW;

  logic signed [PW-1:0] prod [N];
  logic [AW-1:0]        sum;

  genvar c;
  generate
    for (c = 0; c < N; c++) begin : g_mul
      assign prod[c] = $signed(a_row[c*EW +: EW]) * $signed(b_row[c*EW +: EW]);
    end
  endgenerate

  always_comb begin
    sum = acc_in;
    for (int c2 = 0; c2 < N; c2++) begin
      sum = sum + {{(AW-PW){prod[c2][PW-1]}}, prod[c2]};
    end
  end

  assign acc_out = sum;
endmodule

// File: rtl/imma_lane.sv
`timescale 1ns/1ps
// One output element: both mode datapaths computed side by side.
module imma_lane #(
  parameter int ROW_W   = 64,
  parameter int ACC8_W  = 32,
  parameter int ACC16_W = 64
) (
  input  logic [ROW_W-1:0]   lrow,
  input  logic [ROW_W-1:0]   rrow,
  input  logic [ACC8_W-1:0]  acc8_in,
  input  logic [ACC16_W-1:0] acc16_in,
  output logic [ACC8_W-1:0]  res8,
  output logic [ACC16_W-1:0] res16
);
  localparam int N8  = ROW_W / 8;
  localparam int N16 = ROW_W / 16;

  imma_dot #(.EW(8), .N(N8), .AW(ACC8_W)) u_dot8 (
    .a_row  (lrow),
    .b_row  (rrow),
    .acc_in (acc8_in),
    .acc_out(res8)
  );

  imma_dot #(.EW(16), .N(N16), .AW(ACC16_W)) u_dot16 (
    .a_row  (lrow),
    .b_row  (rrow),
    .acc_in (acc16_in),
    .acc_out(res16)
  );
endmodule

// File: rtl/imma_outreg.sv
`timescale 1ns/1ps
// Output register with valid/ready handshake; one entry, full throughput.
module imma_outreg #(
  parameter int W = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_mode,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_mode,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_mode  <= in_mode;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/imma_core.sv
`timescale 1ns/1ps
module imma_core
  import imma_pkg::*;
#(
  parameter int REG_W   = DEF_REG_W,
  parameter int ROWS    = DEF_ROWS,
  parameter int ACC8_W  = DEF_ACC8_W,
  parameter int ACC16_W = DEF_ACC16_W,
  parameter int ACC_W   = ACC16_W * ROWS * ROWS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic [REG_W-1:0] in_lhs,
  input  logic [REG_W-1:0] in_rhs,
  input  logic [ACC_W-1:0] in_acc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_mode,
  output logic [ACC_W-1:0] out_acc
);
  localparam int ROW_W = REG_W / ROWS;
  localparam int NE    = ROWS * ROWS;

  logic [ACC8_W-1:0]  r8  [NE];
  logic [ACC16_W-1:0] r16 [NE];
  logic [ACC_W-1:0]   nxt;
  imma_mode_e         mode;

  assign mode = imma_mode_e'(in_mode);

  genvar i, j;
  generate
    for (i = 0; i < ROWS; i++) begin : g_row
      for (j = 0; j < ROWS; j++) begin : g_col
        // right row j acts as column j of the transposed operand
        imma_lane #(.ROW_W(ROW_W), .ACC8_W(ACC8_W), .ACC16_W(ACC16_W)) u_lane (
          .lrow    (in_lhs[i*ROW_W +: ROW_W]),
          .rrow    (in_rhs[j*ROW_W +: ROW_W]),
          .acc8_in (in_acc[(i*ROWS+j)*ACC8_W +: ACC8_W]),
          .acc16_in(in_acc[(i*ROWS+j)*ACC16_W +: ACC16_W]),
          .res8    (r8[i*ROWS+j]),
          .res16   (r16[i*ROWS+j])
        );
      end
    end
  endgenerate

  always_comb begin
    nxt = '0;
    for (int k = 0; k < NE; k++) begin
      if (mode == MODE_I16) nxt[k*ACC16_W +: ACC16_W] = r16[k];
      else                  nxt[k*ACC8_W  +: ACC8_W ] = r8[k];
    end
  end

  imma_outreg #(.W(ACC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_mode  (in_mode),
    .in_data  (nxt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_mode (out_mode),
    .out_data (out_acc)
  );
endmodule

// File: rtl/imma_core_chk.sv
`timescale 1ns/1ps
module imma_core_chk #(
  parameter int ACC_W = 1024,
  parameter int HALF  = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_mode,
  input logic [ACC_W-1:0] out_acc
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_DRAIN_DROP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_mode))); // R7

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mode) |-> (out_acc[ACC_W-1:HALF] == '0)); // R3
endmodule

bind imma_core imma_core_chk #(.ACC_W(ACC_W), .HALF(ACC8_W*ROWS*ROWS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_mode (out_mode),
  .out_acc  (out_acc)
);

// File: tb/sim_imma_core.sv
`timescale 1ns/1ps
module sim_imma_core;
  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready, in_mode;
  logic [255:0]  in_lhs, in_rhs;
  logic [1023:0] in_acc;
  logic          out_valid, out_ready, out_mode;
  logic [1023:0] out_acc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  imma_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_lhs(in_lhs), .in_rhs(in_rhs), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
    .out_acc(out_acc)
  );

  function automatic logic [1023:0] model(input logic m, input logic [255:0] l,
                                          input logic [255:0] r, input logic [1023:0] a);
    logic [1023:0] res;
    logic signed [31:0] s32;
    logic signed [63:0] s64;
    res = '0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        if (!m) begin
          s32 = $signed(a[(4*i+j)*32 +: 32]);
          for (int c = 0; c < 8; c++)
            s32 = s32 + $signed(l[64*i+8*c +: 8]) * $signed(r[64*j+8*c +: 8]);
          res[(4*i+j)*32 +: 32] = s32;
        end else begin
          s64 = $signed(a[(4*i+j)*64 +: 64]);
          for (int c = 0; c < 4; c++)
            s64 = s64 + $signed(l[64*i+16*c +: 16]) * $signed(r[64*j+16*c +: 16]);
          res[(4*i+j)*64 +: 64] = s64;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [1023:0] rnd1024();
    logic [1023:0] v;
    for (int k = 0; k < 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One request with out_ready=1; result checked right after the accepting edge.
  task automatic run_op(input logic m, input logic [255:0] l, input logic [255:0] r,
                        input logic [1023:0] a);
    logic [1023:0] e;
    e = model(m, l, r, a);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_lhs = l; in_rhs = r; in_acc = a; out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8", "in_ready with consumer ready", {1023'b0, in_ready}, 1024'd1);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R6", "out_valid after accept", {1023'b0, out_valid}, 1024'd1);
    chk(out_mode == m, "R9", "out_mode echo", {1023'b0, out_mode}, {1023'b0, m});
    chk(out_acc == e, m ? "R4" : "R2", "result", out_acc, e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R6", "valid falls after drain", {1023'b0, out_valid}, 1024'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0]  l, r, l2, r2;
    logic [1023:0] a, a2, e, e2;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_lhs = '0; in_rhs = '0;
    in_acc = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {1023'b0, out_valid}, 1024'd0);
    @(negedge clk); rst = 1'b0; #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", {1023'b0, out_valid}, 1024'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {1023'b0, in_ready}, 1024'd1);

    // R2 transpose: left row i all (i+1), right row j has element c = c+1
    l = '0; r = '0;
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 8; c++) begin
        l[64*i+8*c +: 8] = 8'(i + 1);
        r[64*i+8*c +: 8] = 8'(c + 1 + i);
      end
    run_op(1'b0, l, r, '0);
    // element (1,2): 2 * sum(c+3, c=0..7) = 2*52 = 104
    chk(out_acc[6*32 +: 32] == 32'd104, "R2", "element (1,2)", {992'b0, out_acc[6*32 +: 32]}, 1024'd104);

    // R3: upper accumulator registers set to ones must not leak in byte mode
    a = rnd1024(); a[1023:512] = '1;
    run_op(1'b0, rnd256(), rnd256(), a);
    chk(out_acc[1023:512] == '0, "R3", "upper half clear", out_acc, '0);

    // R5 byte wrap: (-128)*(-128)*8 = 131072 added to 0x7FFF0000 crosses sign
    l = {32{8'h80}}; r = {32{8'h80}}; a = '0;
    for (int k = 0; k < 16; k++) a[k*32 +: 32] = 32'h7FFF_0000;
    run_op(1'b0, l, r, a);
    chk(out_acc[31:0] == 32'h8001_0000, "R5", "byte wrap", {992'b0, out_acc[31:0]}, 1024'h8001_0000);
    // R5 signed mix: 127 * -128 * 8 = -130048
    l = {32{8'h7F}}; r = {32{8'h80}};
    run_op(1'b0, l, r, '0);
    chk(out_acc[31:0] == 32'hFFFE_0400, "R5", "byte signed", {992'b0, out_acc[31:0]}, 1024'hFFFE_0400);

    // R4 / R5 halfword: (-32768)^2*4 = 2^32 added to 2^63-1 wraps
    l = {16{16'h8000}}; r = {16{16'h8000}}; a = '0;
    for (int k = 0; k < 16; k++) a[k*64 +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
    run_op(1'b1, l, r, a);
    chk(out_acc[63:0] == 64'h8000_0000_FFFF_FFFF, "R5", "halfword wrap",
        {960'b0, out_acc[63:0]}, {960'b0, 64'h8000_0000_FFFF_FFFF});
    run_op(1'b1, rnd256(), rnd256(), rnd1024());
    idle();

    // R7 / R8 stall: result A held while B waits
    l = rnd256(); r = rnd256(); a = rnd1024(); e = model(1'b1, l, r, a);
    l2 = rnd256(); r2 = rnd256(); a2 = rnd1024(); e2 = model(1'b0, l2, r2, a2);
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b1; in_lhs = l; in_rhs = r; in_acc = a; out_ready = 1'b0;
    @(posedge clk); #1;
    chk(out_acc == e, "R4", "stall first result", out_acc, e);
    @(negedge clk);
    in_mode = 1'b0; in_lhs = l2; in_rhs = r2; in_acc = a2; #1;
    chk(in_ready == 1'b0, "R8", "in_ready low in stall", {1023'b0, in_ready}, 1024'd0);
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      chk(out_valid == 1'b1, "R7", "valid held", {1023'b0, out_valid}, 1024'd1);
      chk(out_acc == e, "R7", "data held", out_acc, e);
      chk(out_mode == 1'b1, "R7", "mode held", {1023'b0, out_mode}, 1024'd1);
    end
    @(negedge clk); out_ready = 1'b1; #1;
    chk(in_ready == 1'b1, "R8", "in_ready when draining", {1023'b0, in_ready}, 1024'd1);
    @(posedge clk); #1;
    chk(out_acc == e2, "R8", "second result after drain", out_acc, e2);
    chk(out_mode == 1'b0, "R9", "mode of second", {1023'b0, out_mode}, 1024'd0);
    idle();

    // Back-to-back random stream, mixed modes
    for (int n = 0; n < 300; n++) begin
      run_op(1'($urandom & 1), rnd256(), rnd256(), rnd1024());
    end
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule